// File: doc/BRIEF.md
# Flash command interface controller

This block sits between a CPU bus and a small byte-wide storage array that behaves like flash memory. The CPU drives operations by writing command bytes: single-cycle commands select what bus reads return (array bytes or a status byte) or clear the error flags. Two-cycle commands first arm an operation and then take its operand on a later write. The operand is the target byte and data for a program, or the block selector for an erase.

A program or erase starts a busy period of a fixed, parameterised number of clock cycles. During that period the block shows the status byte on reads, drives its ready output low and drops every command write. When the period ends, the block updates the array. Programming can only clear bits. Erasing sets bytes to 0xFF. The block also records sticky error flags that stay set until the clear command is written.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `rdy` is 1, reads return array bytes, every array byte is 0xFF and the status byte is 0x80.
- R2: Writing 0xFF (when not busy and no operation is armed) makes every later read return the array byte at `bus_addr`, until another command changes the read view.
- R3: Writing 0x70 makes reads return the status byte. Its bit 7 is ready (1 = idle), bit 5 is the erase error flag, bit 4 is the program error flag, and all other bits read 0.
- R4: Writing 0x50 clears status bits 4 and 5 in one write and leaves the read view unchanged.
- R5: Writing 0x40 and then a write carrying address A and data D programs byte A to (old & D). The block is busy for exactly PROG_CYC cycles, starting with the cycle after the second write.
- R6: Starting a program or erase switches reads to the status byte. The switch is visible in the cycle after the starting write.
- R7: Status bit 7 and `rdy` are both 0 for the whole busy period and 1 otherwise.
- R8: If a programmed byte does not equal D when the operation completes, status bit 4 is set and stays set until a 0x50 write.
- R9: Writing 0x20 and then 0xD0 with an address whose low BLK_W bits are all ones fills that block with 0xFF, leaves other blocks unchanged, and keeps the block busy for ERASE_CYC cycles.
- R10: Writing 0x20 and then 0x20 fills the whole array with 0xFF after ERASE_CYC busy cycles.
- R11: After 0x20, a second byte other than 0xD0 or 0x20, or 0xD0 with an address that is not a block's top address, sets status bit 5 and switches reads to status. It starts no busy period and leaves the array unchanged.
- R12: Command writes during the busy period have no effect, including a write in its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for writes and reads |
| bus_wdata | input | 8 | Command or operand byte |
| bus_rdata | output | 8 | Array byte or status byte, chosen by the read view |
| rdy | output | 1 | 1 when idle, 0 while busy |

## Verification
Two functions can fall in the same cycle: the completion of a busy period, and a command write that arrives in that same final cycle. The bench writes 0xFF exactly on the last busy cycle of a program. It then checks that `rdy` has risen and that reads still return the status byte, because the write must be dropped and not taken as the busy period ends. A 0xFF written one cycle later is accepted and switches reads back to the array. The error-completion path is also exercised: a failed program sets bit 4 in the completion cycle, while no write is accepted.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_VIEW_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_VIEW_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
    localparam logic [7:0] CMD_PROGRAM     = 8'h40;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_ERASE_BLOCK = 8'hD0;

    typedef enum logic {
        VIEW_ARRAY,
        VIEW_STATUS
    } view_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PROG_ARM,
        SEQ_ERASE_ARM,
        SEQ_BUSY
    } seq_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE_BLK,
        OP_ERASE_ALL
    } op_e;

    typedef struct packed {
        op_e        kind;
        logic [7:0] data;
    } job_t;

    function automatic logic [7:0] pack_status(input logic ready,
                                               input logic erase_err,
                                               input logic prog_err);
        return {ready, 1'b0, erase_err, prog_err, 4'b0000};
    endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_erase,
    output logic busy,
    output logic done
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= start_erase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R12
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              prog_fail,
    output logic              start,
    output logic              start_erase,
    output job_t              job,
    output logic [ADDR_W-1:0] job_addr,
    output view_e             view,
    output logic [7:0]        status
);
    seq_e              st_q;
    view_e             view_q;
    logic              prog_err_q;
    logic              erase_err_q;
    job_t              job_q;
    logic [ADDR_W-1:0] job_addr_q;
    logic              accept;
    logic              blk_top;

    assign accept   = we && !busy;
    assign blk_top  = &addr[BLK_W-1:0];
    assign job      = job_q;
    assign job_addr = job_addr_q;
    assign view     = view_q;
    assign status   = pack_status(!busy, erase_err_q, prog_err_q);

    always_comb begin
        start       = 1'b0;
        start_erase = 1'b0;
        if (accept) begin
            if (st_q == SEQ_PROG_ARM) begin
                start = 1'b1;
            end else if (st_q == SEQ_ERASE_ARM) begin
                if ((wdata == CMD_ERASE_BLOCK && blk_top) || wdata == CMD_ERASE) begin
                    start       = 1'b1;
                    start_erase = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SEQ_IDLE;
            view_q      <= VIEW_ARRAY;
            prog_err_q  <= 1'b0;
            erase_err_q <= 1'b0;
            job_q       <= '{kind: OP_NONE, data: 8'h00};
            job_addr_q  <= '0;
        end else begin
            if (done) begin
                st_q <= SEQ_IDLE;
                if (job_q.kind == OP_PROG && prog_fail) prog_err_q <= 1'b1;
            end
            if (accept) begin
                case (st_q)
                    SEQ_IDLE: begin
                        case (wdata)
                            CMD_VIEW_ARRAY:  view_q <= VIEW_ARRAY;
                            CMD_VIEW_STATUS: view_q <= VIEW_STATUS;
                            CMD_CLEAR_ERR: begin
                                prog_err_q  <= 1'b0;
                                erase_err_q <= 1'b0;
                            end
                            CMD_PROGRAM:     st_q <= SEQ_PROG_ARM;
                            CMD_ERASE:       st_q <= SEQ_ERASE_ARM;
                            default: ;
                        endcase
                    end
                    SEQ_PROG_ARM: begin
                        st_q       <= SEQ_BUSY;
                        view_q     <= VIEW_STATUS;
                        job_q      <= '{kind: OP_PROG, data: wdata};
                        job_addr_q <= addr;
                    end
                    SEQ_ERASE_ARM: begin
                        view_q <= VIEW_STATUS;
                        if (start) begin
                            st_q       <= SEQ_BUSY;
                            job_q      <= '{kind: (wdata == CMD_ERASE) ? OP_ERASE_ALL : OP_ERASE_BLK,
                                            data: 8'hFF};
                            job_addr_q <= addr;
                        end else begin
                            st_q        <= SEQ_IDLE;
                            erase_err_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    auto_status_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> view_q == VIEW_STATUS);

    // R4
    clear_err_chk: assert property (@(posedge clk) disable iff (rst)
        accept && st_q == SEQ_IDLE && wdata == CMD_CLEAR_ERR |=> !prog_err_q && !erase_err_q);

    // R8
    prog_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        prog_err_q && !(accept && st_q == SEQ_IDLE && wdata == CMD_CLEAR_ERR) |=> prog_err_q);

    // R11
    bad_erase_chk: assert property (@(posedge clk) disable iff (rst)
        accept && st_q == SEQ_ERASE_ARM && !start |=> erase_err_q && view_q == VIEW_STATUS);

    // R12
    busy_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
        busy && we |=> $stable(view_q) && $stable(erase_err_q));

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  job_t              job,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              prog_fail
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    assign rd_data   = mem[rd_addr];
    assign prog_fail = (mem[job_addr] & job.data) != job.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            case (job.kind)
                OP_PROG: mem[job_addr] <= mem[job_addr] & job.data;
                OP_ERASE_BLK: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if ((ADDR_W'(i) >> BLK_W) == (job_addr >> BLK_W)) mem[i] <= 8'hFF;
                    end
                end
                OP_ERASE_ALL: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BLK_W     = 4,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              rdy
);
    logic              start, start_erase, busy, done, prog_fail;
    job_t              job;
    logic [ADDR_W-1:0] job_addr;
    view_e             view;
    logic [7:0]        status, arr_byte;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
        .clk, .rst, .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .busy, .done, .prog_fail, .start, .start_erase,
        .job, .job_addr, .view, .status
    );

    flash_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
        .clk, .rst, .start, .start_erase, .busy, .done
    );

    flash_byte_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
        .clk, .rst, .commit(done), .job, .job_addr,
        .rd_addr(bus_addr), .rd_data(arr_byte), .prog_fail
    );

    assign bus_rdata = (view == VIEW_STATUS) ? status : arr_byte;
    assign rdy       = !busy;

endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
    localparam int ADDR_W = 6, BLK_W = 4, PROG_CYC = 4, ERASE_CYC = 8;

    logic              clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = 8'h00, bus_rdata;
    logic              rdy;
    int                n_chk = 0, n_bad = 0;
    bit                ended = 1'b0;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC))
    i_flash_cmd_ctrl (.clk, .rst, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .rdy);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 rdy", {7'b0, rdy}, 8'h01);
        rd(6'd0, d);  chk("R1 byte0", d, 8'hFF);
        rd(6'd63, d); chk("R1 byte63", d, 8'hFF);
        wr(6'd0, 8'h70); rd(6'd0, d); chk("R1 R3 status", d, 8'h80);
        wr(6'd0, 8'hFF); rd(6'd9, d); chk("R2 array view", d, 8'hFF);
        idle(3); rd(6'd9, d); chk("R2 view persists", d, 8'hFF);
    endtask

    task automatic t_program_ok;
        logic [7:0] d;
        wr(6'd0, 8'h40); wr(6'd5, 8'hA5);
        chk("R7 rdy low", {7'b0, rdy}, 8'h00);
        rd(6'd5, d); chk("R6 R7 busy status", d, 8'h00);
        idle(PROG_CYC - 1);
        chk("R5 still busy last cycle", {7'b0, rdy}, 8'h00);
        wr(6'd0, 8'hFF);
        chk("R5 ready after PROG_CYC", {7'b0, rdy}, 8'h01);
        rd(6'd5, d); chk("R12 write on last busy cycle dropped", d, 8'h80);
        wr(6'd0, 8'hFF); rd(6'd5, d); chk("R5 programmed byte", d, 8'hA5);
    endtask

    task automatic t_program_fail;
        logic [7:0] d;
        wr(6'd0, 8'h40); wr(6'd5, 8'h5A); idle(PROG_CYC);
        rd(6'd5, d); chk("R8 error flag", d, 8'h90);
        wr(6'd0, 8'hFF); rd(6'd5, d); chk("R5 AND result", d, 8'h00);
        wr(6'd0, 8'h70); rd(6'd5, d); chk("R8 sticky", d, 8'h90);
        wr(6'd0, 8'h50); rd(6'd5, d); chk("R4 cleared, view kept", d, 8'h80);
    endtask

    task automatic t_block_erase;
        logic [7:0] d;
        wr(6'd0, 8'h40); wr(6'h13, 8'h0F); idle(PROG_CYC);
        wr(6'd0, 8'h20); wr(6'h0F, 8'hD0);
        rd(6'd0, d); chk("R9 busy status", d, 8'h00);
        idle(ERASE_CYC - 1);
        chk("R9 still busy last cycle", {7'b0, rdy}, 8'h00);
        idle(1);
        chk("R9 ready after ERASE_CYC", {7'b0, rdy}, 8'h01);
        wr(6'd0, 8'hFF);
        rd(6'd5, d);    chk("R9 block filled", d, 8'hFF);
        rd(6'h13, d);   chk("R9 other block kept", d, 8'h0F);
    endtask

    task automatic t_bad_erase;
        logic [7:0] d;
        wr(6'd0, 8'h20); wr(6'h1E, 8'hD0);
        chk("R11 no busy (address)", {7'b0, rdy}, 8'h01);
        rd(6'd0, d); chk("R11 erase error (address)", d, 8'hA0);
        wr(6'd0, 8'hFF); rd(6'h13, d); chk("R11 array untouched", d, 8'h0F);
        wr(6'd0, 8'h50); wr(6'd0, 8'h20); wr(6'h1F, 8'h33);
        chk("R11 no busy (byte)", {7'b0, rdy}, 8'h01);
        rd(6'd0, d); chk("R11 erase error (byte), status view", d, 8'hA0);
        wr(6'd0, 8'h50); rd(6'd0, d); chk("R4 erase flag cleared", d, 8'h80);
    endtask

    task automatic t_erase_all;
        logic [7:0] d;
        wr(6'd0, 8'h20); wr(6'd0, 8'h20);
        chk("R10 busy", {7'b0, rdy}, 8'h00);
        idle(ERASE_CYC);
        chk("R10 ready", {7'b0, rdy}, 8'h01);
        wr(6'd0, 8'hFF);
        rd(6'h13, d); chk("R10 all filled", d, 8'hFF);
        rd(6'd5, d);  chk("R10 byte5", d, 8'hFF);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_program_ok();
        t_program_fail();
        t_block_erase();
        t_bad_erase();
        t_erase_all();
        finish_run();
    end
endmodule